// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block is the receive side of a clock-driving synchronous serial port working in half-duplex. While it is receiving, it produces the shift clock on a clock pin from a programmable half-period divider. It takes one bit from a single data pin on every falling edge of that clock, least significant bit first. A finished word is placed in a holding register and a receive-complete flag is raised. An interrupt line follows that flag when interrupts are enabled.

Two enables start reception. The single-word enable is set by a pulse and clears itself after one word. The continuous enable is a level, and words are received back to back for as long as it is held. If both are set, reception continues. When the continuous enable is dropped, the overrun error flag is cleared. A 9-bit mode places the ninth received bit in its own status output. A polarity input selects the idle level of the clock pin and inverts that pin.

Top module: `sync_master_rx`

## Requirements
- R1: Reception runs only while port_en_i and sync_master_i are both high and at least one enable is active (single_busy_o or cont_en_i). Otherwise the internal clock is held low, so sclk_o equals clk_pol_i. A single_set_i pulse while the port is off is ignored.
- R2: While running, the internal clock toggles once every divisor_i+1 cycles of clk_i. sclk_o is the internal clock XOR clk_pol_i.
- R3: A bit is taken from data_i at each high-to-low transition of the internal clock. The first bit taken is bit 0 of the word.
- R4: A single_set_i pulse sets single_busy_o. The flag clears itself in the cycle the word completes, and the clock then stays idle.
- R5: With cont_en_i high, words are received back to back until it drops. If single_busy_o is also set, reception continues past the first word.
- R6: With nine_bit_i high, a word is 9 bits. rx_byte_o holds bits 0 to 7 and rx_bit8_o holds bit 8. In 8-bit mode rx_bit8_o is 0.
- R7: rx_done_o is set one cycle after a word completes and cleared by an rd_i pulse. irq_o equals rx_done_o AND irq_en_i.
- R8: If a word completes while rx_done_o is set and rd_i is low, that word is discarded, overrun_o is set, and rx_byte_o keeps its old value.
- R9: overrun_o is cleared in the cycle after cont_en_i falls, or while the port is off.
- R10: After reset, every output is 0 except sclk_o, which equals clk_pol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Port enable |
| sync_master_i | input | 1 | Synchronous master mode select |
| single_set_i | input | 1 | Pulse that arms a single-word receive |
| cont_en_i | input | 1 | Continuous receive enable |
| clk_pol_i | input | 1 | Clock pin idle level and inversion |
| nine_bit_i | input | 1 | 9-bit word mode |
| divisor_i | input | 16 | Half-period divisor (period minus one) |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Read strobe for the received byte |
| data_i | input | 1 | Serial data pin |
| sclk_o | output | 1 | Generated shift clock pin |
| single_busy_o | output | 1 | Single-word enable state |
| rx_byte_o | output | 8 | Received byte |
| rx_bit8_o | output | 1 | Ninth received bit |
| rx_done_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun error flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest states to reach are the overrun and its clearing, and a read strobe that lands in the same cycle a word completes. The first needs a second word to finish while the first is still unread. The bench reaches it by running continuous mode with reads withheld for two word times, then dropping the continuous enable. A random phase issues sparse read strobes and flips the enables now and then. That puts reads, enable changes and word completions in the same cycle, and a behavioural model checks every cycle.

// File: rtl/smrx_pkg.sv
package smrx_pkg;
  localparam int DIV_W  = 16;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic              bit8;
    logic [BYTE_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/smrx_clkgen.sv
module smrx_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == '0);
  assign fall_o = tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= div_i;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= div_i;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_q);
  a_r2_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != '0) |=> $stable(sck_q));
  a_r3_fall_from_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !sck_q);
endmodule

// File: rtl/smrx_shifter.sv
module smrx_shifter
  import smrx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     fall_i,
  input  logic     nine_i,
  input  logic     data_i,
  output logic     done_o,
  output rx_word_t word_o
);
  logic [WORD_W-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0]  bits_q;
  logic [CNT_W-1:0]  last;

  assign last   = nine_i ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
  assign sh_nxt = {data_i, sh_q[WORD_W-1:1]};
  assign done_o = fall_i && (bits_q >= last);

  // LSB first: the earliest bit ends up lowest after the final shift
  always_comb begin
    if (nine_i) begin
      word_o.data = sh_nxt[BYTE_W-1:0];
      word_o.bit8 = sh_nxt[WORD_W-1];
    end else begin
      word_o.data = sh_nxt[WORD_W-1:1];
      word_o.bit8 = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (!run_i) begin
      sh_q   <= '0;
      bits_q <= '0;
    end else if (fall_i) begin
      sh_q   <= sh_nxt;
      bits_q <= done_o ? '0 : bits_q + 1'b1;
    end
  end

  a_r6_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q <= CNT_W'(WORD_W - 1));
  a_r3_shift_only_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fall_i) |=> $stable(bits_q));
endmodule

// File: rtl/smrx_hold.sv
module smrx_hold
  import smrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_done_i,
  input  rx_word_t          word_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              bit8_o,
  output logic              done_o,
  output logic              ovr_o
);
  rx_word_t hold_q;
  logic     done_q, ovr_q;
  logic     pending;

  assign pending = done_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (word_done_i && !pending) hold_q <= word_i;
      done_q <= pending || word_done_i;
      if (clr_err_i)                   ovr_q <= 1'b0;
      else if (word_done_i && pending) ovr_q <= 1'b1;
    end
  end

  assign byte_o = hold_q.data;
  assign bit8_o = hold_q.bit8;
  assign done_o = done_q;
  assign ovr_o  = ovr_q;

  a_r8_keep_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rd_i) |=> $stable(hold_q));
  a_r8_ovr_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> done_q);
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !word_done_i) |=> !done_q);
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import smrx_pkg::*;
#(
  parameter int DIV_WIDTH = DIV_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 port_en_i,
  input  logic                 sync_master_i,
  input  logic                 single_set_i,
  input  logic                 cont_en_i,
  input  logic                 clk_pol_i,
  input  logic                 nine_bit_i,
  input  logic [DIV_WIDTH-1:0] divisor_i,
  input  logic                 irq_en_i,
  input  logic                 rd_i,
  input  logic                 data_i,
  output logic                 sclk_o,
  output logic                 single_busy_o,
  output logic [BYTE_W-1:0]    rx_byte_o,
  output logic                 rx_bit8_o,
  output logic                 rx_done_o,
  output logic                 overrun_o,
  output logic                 irq_o
);
  logic     port_ok, active;
  logic     single_q, cont_q;
  logic     sck, fall, word_done, clr_err;
  rx_word_t word;

  assign port_ok = port_en_i && sync_master_i;
  assign active  = port_ok && (cont_en_i || single_q);
  assign clr_err = !port_ok || (cont_q && !cont_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      single_q <= port_ok && (single_set_i || (single_q && !word_done));
      cont_q   <= cont_en_i;
    end
  end

  smrx_clkgen #(.DIV_W(DIV_WIDTH)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (divisor_i),
    .sck_o  (sck),
    .fall_o (fall)
  );

  smrx_shifter u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .fall_i (fall),
    .nine_i (nine_bit_i),
    .data_i (data_i),
    .done_o (word_done),
    .word_o (word)
  );

  smrx_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_done_i (word_done),
    .word_i      (word),
    .rd_i        (rd_i),
    .clr_err_i   (clr_err),
    .byte_o      (rx_byte_o),
    .bit8_o      (rx_bit8_o),
    .done_o      (rx_done_o),
    .ovr_o       (overrun_o)
  );

  assign sclk_o        = sck ^ clk_pol_i;
  assign single_busy_o = single_q;
  assign irq_o         = rx_done_o && irq_en_i;

  a_r4_single_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && !single_set_i) |=> !single_q);
  a_r9_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_q && !cont_en_i) |=> !overrun_o);
  a_r7_done_follows_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |=> rx_done_o);
endmodule

// File: tb/sync_master_rx_bench.sv
module sync_master_rx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        port_en_i = 0, sync_master_i = 0, single_set_i = 0, cont_en_i = 0;
  logic        clk_pol_i = 0, nine_bit_i = 0, irq_en_i = 0, rd_i = 0, data_i = 0;
  logic [15:0] divisor_i = 16'd2;
  logic        sclk_o, single_busy_o, rx_bit8_o, rx_done_o, overrun_o, irq_o;
  logic [7:0]  rx_byte_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  sync_master_rx u_sync_master_rx (.*);

  // behavioural reference model
  int       m_cnt, m_bits, m_sh, w_idx;
  bit       m_sck, m_single, m_done, m_ovr, m_b8, m_cont_q, m_active;
  int       m_byte, cur_word, last_sent, n_words;

  function automatic int pat(int i);
    return (i * 151 + 29) & 9'h1FF;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_bits = 0; m_sh = 0; m_sck = 0; m_single = 0; m_done = 0;
      m_ovr = 0; m_b8 = 0; m_cont_q = 0; m_byte = 0; m_active = 0;
      w_idx = 0; cur_word = pat(0); last_sent = 0; n_words = 0;
    end else begin
      bit port_ok, complete, d;
      int w;
      complete = 0; w = 0;
      port_ok  = port_en_i && sync_master_i;
      m_active = port_ok && (cont_en_i || m_single);
      if (!m_active) begin
        m_cnt = divisor_i; m_sck = 0; m_bits = 0; m_sh = 0;
      end else if (m_cnt == 0) begin
        m_cnt = divisor_i;
        if (m_sck) begin
          m_sh = m_sh | (int'(data_i) << m_bits);
          m_bits++;
          if (m_bits >= (nine_bit_i ? 9 : 8)) begin
            complete = 1; w = m_sh; m_sh = 0; m_bits = 0;
            last_sent = cur_word; w_idx++; cur_word = pat(w_idx); n_words++;
          end
        end
        m_sck = !m_sck;
      end else m_cnt--;
      d = m_done && !rd_i;
      if (complete) begin
        if (d) m_ovr = 1;
        else begin
          m_byte = w & 8'hFF; m_b8 = nine_bit_i ? w[8] : 1'b0; d = 1;
        end
      end
      m_done = d;
      m_single = port_ok && (single_set_i || (m_single && !complete));
      if (!port_ok || (m_cont_q && !cont_en_i)) m_ovr = 0;
      m_cont_q = cont_en_i;
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison, sampled away from the edge
  always @(posedge clk_i) begin
    #5;
    if (rst_ni) begin
      check("R1/R2 sclk",   sclk_o, m_sck ^ clk_pol_i);
      check("R4 busy",      single_busy_o, m_single);
      check("R3/R6 byte",   rx_byte_o, m_byte);
      check("R6 bit8",      rx_bit8_o, m_b8);
      check("R7 done",      rx_done_o, m_done);
      check("R8/R9 ovr",    overrun_o, m_ovr);
      check("R7 irq",       irq_o, m_done && irq_en_i);
    end
  end

  // data pin follows the word being sent, bit by bit
  always @(negedge clk_i) data_i <= cur_word[m_bits];

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_single();
    @(negedge clk_i) single_set_i = 1;
    @(negedge clk_i) single_set_i = 0;
  endtask

  task automatic do_read();
    @(negedge clk_i) rd_i = 1;
    @(negedge clk_i) rd_i = 0;
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim && !rx_done_o; i++) @(negedge clk_i);
  endtask

  task automatic wait_words(int k, int lim);
    int start = n_words;
    for (int i = 0; i < lim && n_words < start + k; i++) @(negedge clk_i);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int first, t0, t1;
    cyc(3);
    // R10 reset state
    check("R10 done", rx_done_o, 0); check("R10 ovr", overrun_o, 0);
    check("R10 sclk", sclk_o, 0);    check("R10 byte", rx_byte_o, 0);
    @(negedge clk_i) rst_ni = 1;
    // R1 ignored while port off
    pulse_single(); cyc(2);
    check("R1 set ignored", single_busy_o, 0);
    port_en_i = 1; sync_master_i = 1; cyc(20);
    check("R1 idle clock", sclk_o, 0);
    clk_pol_i = 1; cyc(2);
    check("R2 idle pol", sclk_o, 1);
    clk_pol_i = 0;
    // R4 single word, R3 LSB first, R2 period
    divisor_i = 16'd3;
    pulse_single();
    check("R4 armed", single_busy_o, 1);
    @(posedge sclk_o); t0 = $time; @(negedge sclk_o); t1 = $time;
    check("R2 half period", (t1 - t0) / 20, 4);
    wait_done(200);
    check("R3 byte", rx_byte_o, last_sent & 8'hFF);
    check("R6 bit8 low", rx_bit8_o, 0);
    check("R4 self clear", single_busy_o, 0);
    check("R7 irq gated", irq_o, 0);
    irq_en_i = 1; cyc(30);
    check("R7 irq", irq_o, 1);
    check("R4 clock idle", sclk_o, 0);
    do_read(); cyc(1);
    check("R7 read clears", rx_done_o, 0);
    // R6 nine-bit, fastest clock, inverted pin
    nine_bit_i = 1; divisor_i = 0; clk_pol_i = 1;
    pulse_single(); wait_done(200);
    check("R6 byte", rx_byte_o, last_sent & 8'hFF);
    check("R6 bit8", rx_bit8_o, (last_sent >> 8) & 1);
    do_read(); nine_bit_i = 0; clk_pol_i = 0; cyc(3);
    // R5 continuous with reads, both enables set
    divisor_i = 1; cont_en_i = 1; pulse_single();
    for (int k = 0; k < 4; k++) begin
      wait_done(400);
      check("R5 stream byte", rx_byte_o, last_sent & 8'hFF);
      do_read();
    end
    check("R5 precedence", single_busy_o, 0);
    cyc(5);
    check("R5 still running", m_active, 1);
    // R8 overrun: two words without reads
    wait_done(400); first = last_sent;
    wait_words(2, 400); cyc(2);
    check("R8 overrun", overrun_o, 1);
    check("R8 kept byte", rx_byte_o, first & 8'hFF);
    @(negedge clk_i) cont_en_i = 0; cyc(2);
    check("R9 cleared", overrun_o, 0);
    do_read(); cyc(20);
    // random phase
    divisor_i = 2;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk_i);
      rd_i = ($urandom % 10) == 0;
      single_set_i = ($urandom % 150) == 0;
      if (($urandom % 250) == 0) cont_en_i = !cont_en_i;
      if (($urandom % 700) == 0) port_en_i = !port_en_i;
      if (($urandom % 400) == 0) clk_pol_i = !clk_pol_i;
      if (($urandom % 300) == 0) irq_en_i = !irq_en_i;
      if (!port_en_i && ($urandom % 50) == 0) port_en_i = 1;
    end
    rd_i = 0; single_set_i = 0; cyc(4);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule